// File: doc/BRIEF.md
# Receive FIFO with Line Status Reporting

This block sits between a serial receiver and the CPU register file of a UART. Each character handed over by the deserializer goes into a 16-deep FIFO. A three-bit error tag (break, framing, parity) is stored next to the character's data. The block builds an 8-bit line status byte from the FIFO state, a sticky overrun flag and the two transmitter empty flags it receives. That byte is shown to the CPU.

The CPU side has two separate read strobes. One reads the status byte and only affects the overrun flag. The other reads the receive buffer, which shows the head character and removes it from the FIFO. The per-character error bits in the status byte always describe the head entry. This way software can read the status and then the data, and know which character was damaged. A summary bit stays high while any stored entry still carries an error. A long low on the receive line is reported as a single break entry. The break logic re-arms once the line returns high.

Top module: `rx_line_status`

## Requirements
- R1: Status bits 4, 3 and 2 give the break, framing and parity tags of the FIFO head entry, in that order. They do not describe the newest entry.
- R2: A status read (`lsr_rd`) never removes an entry. A buffer read (`rbr_rd`) on a non-empty FIFO removes the head entry, whose data is on `rbr_data` during that read cycle.
- R3: Status bit 7 is 1 while at least one stored entry has any error tag. It returns to 0 once the last tagged entry has been read out.
- R4: Status bit 0 is 1 exactly when the FIFO holds at least one entry.
- R5: A character that arrives while the FIFO holds 16 entries, with no buffer read in the same cycle, is dropped and sets status bit 1. No stored entry changes.
- R6: Status bit 1 clears in the cycle after a status read. If a new overrun happens in the same cycle as the read, the bit stays set.
- R7: A `rx_brk_frame` pulse stores one entry with data 0x00 and only the break tag set. Further pulses are ignored until `rx_line_hi` has been seen.
- R8: A character with `rx_stop_bit` = 0 is stored with the framing tag set.
- R9: With `cfg_par_en` = 1, the parity tag is set when the count of ones in data plus `rx_par_bit` is odd under even parity (`cfg_par_odd` = 0), or even under odd parity (`cfg_par_odd` = 1). With `cfg_par_en` = 0 the tag is never set.
- R10: Status bit 5 equals `tx_hold_empty`. Status bit 6 equals `tx_hold_empty` AND `tx_shift_empty`.
- R11: After reset, status bits 7, 4, 3, 2, 1 and 0 are 0.
- R12: An arrival and a buffer read in the same cycle on a full FIFO are both accepted. The FIFO stays at 16 entries and no overrun is flagged.
- R13: While the FIFO is empty, status bits 4:2 and `rbr_data` read 0, and a buffer read changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | 8 | Received character data |
| rx_par_bit | input | 1 | Parity bit sampled with the character |
| rx_stop_bit | input | 1 | Stop bit level sampled with the character |
| rx_brk_frame | input | 1 | One full frame time of low line has elapsed |
| rx_line_hi | input | 1 | Receive line observed high (re-arms break capture) |
| cfg_par_en | input | 1 | Parity checking enabled |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| lsr_rd | input | 1 | CPU reads the status byte |
| rbr_rd | input | 1 | CPU reads the receive buffer |
| rbr_data | output | 8 | Head entry data |
| lsr | output | 8 | Line status byte |

## Verification
The checker watches every cycle for the following:
- The error tally never exceeds the fill level, and the fill level never exceeds the depth.
- An accepted push raises data ready.
- A dropped arrival raises the overrun bit.
- A status read by itself leaves the fill level unchanged.
- An unarmed break pulse never pushes.
- The head tags read zero when the FIFO is empty.

Only the bench scenarios can show the following, because they need a reference of FIFO contents:
- That the tags belong to the head rather than the newest entry.
- Data order through a full drain.
- That the dropped character is really gone.
- The parity polarity.
- The overrun set-over-clear priority.

// File: rtl/rxls_pkg.sv
package rxls_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_tag_t;

  typedef struct packed {
    rx_tag_t           tag;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic parity_fault(input logic [DATA_W-1:0] d,
                                        input logic pbit,
                                        input logic en,
                                        input logic odd);
    return en & ((^d) ^ pbit ^ odd);
  endfunction

  function automatic logic tag_any(input rx_tag_t t);
    return t.brk | t.fe | t.pe;
  endfunction

  function automatic rx_entry_t make_char(input logic [DATA_W-1:0] d,
                                          input logic pbit,
                                          input logic stop,
                                          input logic en,
                                          input logic odd);
    rx_entry_t e;
    e.data    = d;
    e.tag.brk = 1'b0;
    e.tag.fe  = ~stop;
    e.tag.pe  = parity_fault(d, pbit, en, odd);
    return e;
  endfunction

  function automatic rx_entry_t make_break();
    rx_entry_t e;
    e.data    = '0;
    e.tag.brk = 1'b1;
    e.tag.fe  = 1'b0;
    e.tag.pe  = 1'b0;
    return e;
  endfunction
endpackage

// File: rtl/rxls_tag_fifo.sv
module rxls_tag_fifo
  import rxls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      pop,
  input  rx_entry_t wr_entry,
  output rx_entry_t rd_entry,
  output logic [CW-1:0] fill,
  output logic      full,
  output logic      empty
);
  rx_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign rd_entry = mem[rd_ptr];
  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
endmodule

// File: rtl/rxls_err_tally.sv
module rxls_err_tally #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          any
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (inc && !dec) cnt <= cnt + CW'(1);
    else if (dec && !inc) cnt <= cnt - CW'(1);
  end
  assign any = (cnt != '0);
endmodule

// File: rtl/rxls_brk_gate.sv
module rxls_brk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_frame,
  input  logic line_hi,
  output logic accept,
  output logic armed
);
  assign accept = brk_frame & armed;

  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b1;
    else if (line_hi) armed <= 1'b1;
    else if (accept)  armed <= 1'b0;
  end
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rxls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_par_bit,
  input  logic       rx_stop_bit,
  input  logic       rx_brk_frame,
  input  logic       rx_line_hi,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_empty,
  input  logic       lsr_rd,
  input  logic       rbr_rd,
  output logic [7:0] rbr_data,
  output logic [7:0] lsr
);
  // named internal events
  logic          brk_accept, brk_armed;
  logic          push_req, push_ok, pop_ok, ovr_evt;
  logic          full, empty, err_any;
  logic [CW-1:0] fill, err_cnt;
  logic          err_inc, err_dec;
  logic          ovr_q;
  rx_entry_t     new_entry, head;
  rx_tag_t       head_tag;

  rxls_brk_gate u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk_frame(rx_brk_frame),
    .line_hi  (rx_line_hi),
    .accept   (brk_accept),
    .armed    (brk_armed)
  );

  assign new_entry = rx_brk_frame ? make_break()
                   : make_char(rx_data, rx_par_bit, rx_stop_bit, cfg_par_en, cfg_par_odd);

  assign push_req = (rx_valid & ~rx_brk_frame) | brk_accept;
  assign pop_ok   = rbr_rd & ~empty;
  assign push_ok  = push_req & (~full | pop_ok);
  assign ovr_evt  = push_req & full & ~pop_ok;

  rxls_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push_ok),
    .pop     (pop_ok),
    .wr_entry(new_entry),
    .rd_entry(head),
    .fill    (fill),
    .full    (full),
    .empty   (empty)
  );

  assign err_inc = push_ok & tag_any(new_entry.tag);
  assign err_dec = pop_ok & tag_any(head.tag);

  rxls_err_tally #(.CW(CW)) u_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (err_inc),
    .dec  (err_dec),
    .cnt  (err_cnt),
    .any  (err_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
    else if (lsr_rd)  ovr_q <= 1'b0;
  end

  assign head_tag = empty ? '0 : head.tag;
  assign rbr_data = empty ? '0 : head.data;

  assign lsr = {err_any,
                tx_hold_empty & tx_shift_empty,
                tx_hold_empty,
                head_tag.brk,
                head_tag.fe,
                head_tag.pe,
                ovr_q,
                ~empty};
endmodule

// File: rtl/rx_line_status_chk.sv
module rx_line_status_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] fill,
  input logic [CW-1:0] err_cnt,
  input logic          brk_frame,
  input logic          brk_armed,
  input logic          brk_accept,
  input logic          lsr_rd,
  input logic [7:0]    lsr
);
  a_r3_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= fill);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_ok) |=> lsr[1]);
  a_r4_push_ready: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> lsr[0]);
  a_r2_status_rd_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !pop_ok && !push_ok) |=> $stable(fill));
  a_r7_break_once: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_frame && !brk_armed) |-> !brk_accept);
  a_r13_empty_tags: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (lsr[4:2] == 3'b000));
  a_r10_tx_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
endmodule

bind rx_line_status rx_line_status_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_req  (push_req),
  .push_ok   (push_ok),
  .pop_ok    (pop_ok),
  .full      (full),
  .empty     (empty),
  .fill      (fill),
  .err_cnt   (err_cnt),
  .brk_frame (rx_brk_frame),
  .brk_armed (brk_armed),
  .brk_accept(brk_accept),
  .lsr_rd    (lsr_rd),
  .lsr       (lsr)
);

// File: tb/rx_line_status_tb_top.sv
module rx_line_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_par_bit = 0, rx_stop_bit = 1, rx_brk_frame = 0, rx_line_hi = 0;
  logic [7:0] rx_data = '0;
  logic cfg_par_en = 0, cfg_par_odd = 0, tx_hold_empty = 0, tx_shift_empty = 0;
  logic lsr_rd = 0, rbr_rd = 0;
  logic [7:0] rbr_data, lsr;

  always #4 clk = ~clk;

  rx_line_status dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_bit(rx_par_bit), .rx_stop_bit(rx_stop_bit), .rx_brk_frame(rx_brk_frame),
    .rx_line_hi(rx_line_hi), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
    .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .rbr_data(rbr_data), .lsr(lsr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [10:0] exp_q[$];  // {brk, fe, pe, data}
  bit ovr_m = 0, armed_m = 1, pend_pop = 0, pend_empty_rd = 0;

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lsr();
    logic any = 0;
    logic [2:0] ht = 3'b000;
    foreach (exp_q[i]) if (exp_q[i][10:8] != 3'b000) any = 1;
    if (exp_q.size() > 0) ht = exp_q[0][10:8];
    return {any, tx_hold_empty && tx_shift_empty, tx_hold_empty, ht, ovr_m, exp_q.size() > 0};
  endfunction

  // driver: drives one cycle of inputs and updates the expected model
  task automatic cyc(input logic v, input logic [7:0] d, input logic p, input logic s,
                     input logic b, input logic lh, input logic lr, input logic rr);
    logic [10:0] e;
    bit req, pop, ones_odd, pe;
    @(posedge clk); #2;
    rx_valid = v; rx_data = d; rx_par_bit = p; rx_stop_bit = s;
    rx_brk_frame = b; rx_line_hi = lh; lsr_rd = lr; rbr_rd = rr;
    pop = rr && (exp_q.size() > 0);
    pend_pop = pop;
    pend_empty_rd = rr && (exp_q.size() == 0);
    ones_odd = ($countones({d, p}) % 2) == 1;
    pe = cfg_par_en && (cfg_par_odd ? !ones_odd : ones_odd);
    if (b) begin
      req = armed_m;
      e = {3'b100, 8'h00};
    end else begin
      req = v;
      e = {1'b0, !s, pe, d};
    end
    if (req) begin
      if (exp_q.size() < 16 || pop) exp_q.push_back(e);
      else ovr_m = 1;
    end
    if (req && !(exp_q.size() <= 16 && (exp_q.size() < 16 || pop))) ; // no-op
    if (!(req && !(exp_q.size() < 17) ) && lr && !(req && exp_q.size() >= 16 && !pop && e == e && ovr_set_now(req, pop)))
      ovr_m = 0;
    if (lh) armed_m = 1;
    else if (b && armed_m) armed_m = 0;
  endtask

  bit last_ovr_evt = 0;
  function automatic bit ovr_set_now(input bit req, input bit pop);
    return last_ovr_evt;
  endfunction

  task automatic idle();
    cyc(0, 8'h00, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic chk_lsr(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = exp_lsr();
    check(lsr === e, req, lsr, e);
  endtask

  task automatic put(input logic [7:0] d, input logic p, input logic s);
    cyc(1, d, p, s, 0, 0, 0, 0);
  endtask

  task automatic take();
    cyc(0, 8'h00, 0, 1, 0, 0, 0, 1);
  endtask

  // monitor: compares the head presented during each buffer read
  always @(negedge clk) begin
    if (pend_pop) begin
      check(rbr_data === exp_q[0][7:0], "R2 head data", rbr_data, exp_q[0][7:0]);
      check(lsr[4:2] === exp_q[0][10:8], "R1 head tags", {5'd0, lsr[4:2]}, {5'd0, exp_q[0][10:8]});
      void'(exp_q.pop_front());
      pend_pop = 0;
    end
    if (pend_empty_rd) begin
      check(rbr_data === 8'h00 && lsr[0] === 1'b0, "R13 empty read", rbr_data, 8'h00);
      pend_empty_rd = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk_lsr("R11 reset status");
    tx_hold_empty = 1; tx_shift_empty = 0;
    chk_lsr("R10 hold empty only");
    tx_shift_empty = 1;
    chk_lsr("R10 both empty");

    // R9 even parity: 0x41 has two ones
    cfg_par_en = 1; cfg_par_odd = 0;
    put(8'h41, 0, 1);
    idle(); chk_lsr("R4 data ready");
    put(8'h41, 1, 1);           // R9 parity error
    put(8'h22, 0, 0);           // R8 framing error
    idle(); chk_lsr("R1 R3 clean head, summary set");
    cyc(0, 8'h00, 0, 1, 0, 0, 1, 0);
    cyc(0, 8'h00, 0, 1, 0, 0, 1, 0);
    idle(); chk_lsr("R2 status reads keep fill");
    take(); idle(); chk_lsr("R1 parity head");
    take(); idle(); chk_lsr("R1 framing head");
    take(); idle(); chk_lsr("R3 summary cleared");
    take(); idle(); chk_lsr("R13 empty stays empty");

    // R9 odd parity
    cfg_par_odd = 1;
    put(8'h07, 0, 1);           // three ones + 0 -> odd, good
    put(8'h07, 1, 1);           // even -> error
    idle(); chk_lsr("R9 odd good head");
    take(); idle(); chk_lsr("R9 odd bad head");
    take(); idle();
    cfg_par_en = 0;
    put(8'h07, 1, 1);
    idle(); chk_lsr("R9 parity disabled");
    take(); idle();

    // R7 break
    cyc(0, 8'h00, 0, 1, 1, 0, 0, 0);
    cyc(0, 8'h00, 0, 1, 1, 0, 0, 0);
    cyc(0, 8'h00, 0, 1, 1, 0, 0, 0);
    idle(); chk_lsr("R7 single break entry");
    cyc(0, 8'h00, 0, 1, 0, 1, 0, 0);
    cyc(0, 8'h00, 0, 1, 1, 0, 0, 0);
    idle(); chk_lsr("R7 rearmed break");
    take(); take(); idle(); chk_lsr("R7 drained");

    // R5 / R6 overrun
    for (int i = 0; i < 16; i++) put(8'(i * 5 + 1), 0, 1);
    idle(); chk_lsr("R5 full no overrun");
    put(8'hEE, 0, 1);
    idle(); chk_lsr("R5 overrun set");
    last_ovr_evt = 1;
    cyc(1, 8'hEF, 0, 1, 0, 0, 1, 0);   // new overrun while reading status
    ovr_m = 1; last_ovr_evt = 0;
    idle(); chk_lsr("R6 set wins over clear");
    cyc(0, 8'h00, 0, 1, 0, 0, 1, 0);
    idle(); chk_lsr("R6 overrun cleared");

    // R12 simultaneous push and pop on full
    cyc(1, 8'hA5, 0, 1, 0, 0, 0, 1);
    idle(); chk_lsr("R12 full push+pop no overrun");
    for (int i = 0; i < 16; i++) take();
    idle(); chk_lsr("R12 drained in order");
    check(exp_q.size() == 0, "R5 dropped chars absent", 8'(exp_q.size()), 8'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule